// File: doc/BRIEF.md
# Privilege-Filtered Machine Cycle Counter

This block keeps a 64-bit machine cycle counter. The counter advances on an external tick that does not depend on instruction retirement. A 64-bit configuration register holds one inhibit bit per privilege mode. When the inhibit bit for the mode the hart is running in is set, the counter holds for that tick.

Software reaches the configuration and the counter through a 32-bit CSR port. Each 32-bit half has its own address. Only the upper configuration half carries live bits. Parameters state whether supervisor mode and virtualization are implemented. Inhibit bits for modes that are absent are tied to zero.

The block does not trap. An access from a mode below machine mode raises a combinational illegal flag for the trap logic to act on, and the block suppresses that access.

Top module: `cyc_cnt_filter`

## Requirements
- R1: After reset the counter reads 0 and every inhibit bit reads 0, so a tick advances the counter in every mode.
- R2: The upper configuration half at address 0x721 reads as configuration bits 63:32. Bit 31 of that half always reads 0, and writing 1 to it has no effect.
- R3: Inhibit bits sit in the upper half as follows: bit 30 for M, bit 29 for S/HS, bit 28 for U, bit 27 for VS and bit 26 for VU. The mode input uses priv_i = 3 for M, 1 for S and 0 for U. When virt_i = 1 and priv_i is 1, the mode is VS. When virt_i = 1 and priv_i is 0, the mode is VU.
- R4: In a cycle with tick_i = 1 and no counter write, the counter advances by exactly 1 if the inhibit bit of the current mode is 0. It holds if that bit is 1. With tick_i = 0 it holds.
- R5: Inhibit bits of unimplemented modes read 0 and ignore writes. With HAS_H = 0, bits 27 and 26 are tied to 0 and virt_i is ignored. With HAS_S = 0, bits 29, 27 and 26 are tied to 0.
- R6: The reserved bits 25:0 of the upper half, and the whole lower configuration half at 0x321, read 0 and are left unchanged by writes.
- R7: An access with csr_valid = 1 to any of the four block addresses while priv_i is not 3 drives csr_illegal = 1 in the same cycle. That access returns csr_rdata = 0 and changes no state.
- R8: Counter bits 31:0 are at address 0xB00 and bits 63:32 are at 0xB80. Both are readable and writable. An increment carries from the lower half into the upper half.
- R9: A counter write in a cycle with an enabled tick loads the written value, and that tick adds nothing.
- R10: An inhibit value written in cycle N governs counting from cycle N+1. The tick in cycle N is filtered by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | CSR access strobe |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, 0 when illegal or unmapped |
| csr_illegal | output | 1 | Access from below machine mode to a block address |
| priv_i | input | 2 | Current privilege level (3 M, 1 S, 0 U) |
| virt_i | input | 1 | Hart runs virtualized (VS/VU) |
| tick_i | input | 1 | Count tick |
| count_o | output | 64 | Current counter value |

## Verification
The bench walks a table that sets inhibit masks against each of the five modes. A design that decodes the mode wrongly or reads the wrong bit position counts when it should hold, or holds when it should count. A second instance with supervisor and virtualization removed reads back the tied-zero bits and counts in U mode with virt_i set while only the VS and VU inhibits are written. A design that kept storage for those bits, or honoured virt_i there, would stop counting.

Directed tests cover the write racing a tick, where a design without write priority ends one count high. They cover the inhibit written in the same cycle as a tick, where an early update loses that tick. They also cover the carry across the 32-bit boundary and suppression of writes from user and virtualized modes, where a leaky design would change the configuration.

// File: rtl/cyc_filt_pkg.sv
// Package: shared constants for the privilege-filtered cycle counter.
// Assumes a 32-bit CSR data path and five privilege modes.
package cyc_filt_pkg;

    localparam int NUM_INH = 5;
    localparam int INH_LSB = 26;

    // Inhibit vector index order, matching upper-half bits 26 + index.
    localparam int IDX_VU = 0;
    localparam int IDX_VS = 1;
    localparam int IDX_U  = 2;
    localparam int IDX_S  = 3;
    localparam int IDX_M  = 4;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam logic [11:0] ADDR_CFG_LO = 12'h321;
    localparam logic [11:0] ADDR_CFG_HI = 12'h721;
    localparam logic [11:0] ADDR_CNT_LO = 12'hB00;
    localparam logic [11:0] ADDR_CNT_HI = 12'hB80;

    // Which inhibit bits have a real mode behind them.
    function automatic logic [NUM_INH-1:0] impl_mask(input bit has_s, input bit has_h);
        logic [NUM_INH-1:0] m;
        m         = '0;
        m[IDX_M]  = 1'b1;
        m[IDX_U]  = 1'b1;
        m[IDX_S]  = has_s;
        m[IDX_VS] = has_s & has_h;
        m[IDX_VU] = has_s & has_h;
        return m;
    endfunction

endpackage

// File: rtl/cyc_cfg_reg.sv
// Inhibit-bit storage. Only implemented modes get a flop; the others are
// tied to zero. Assumes the write enable is already qualified by privilege.
module cyc_cfg_reg
    import cyc_filt_pkg::*;
#(
    parameter bit HAS_S = 1'b1,
    parameter bit HAS_H = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NUM_INH-1:0] wdata,
    output logic [NUM_INH-1:0] inh_q
);

    localparam logic [NUM_INH-1:0] IMPL = impl_mask(HAS_S, HAS_H);

    for (genvar i = 0; i < NUM_INH; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            logic bit_q;
            // Hold one inhibit bit; cleared on reset, loaded on write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (we)
                    bit_q <= wdata[i];
            end
            assign inh_q[i] = bit_q;
        end else begin : g_tied
            assign inh_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/cyc_mode_gate.sv
// Mode decoder and tick gate. It turns the privilege and virtualization
// inputs into a one-hot mode, then masks the tick with that mode's inhibit
// bit. Reserved privilege encoding 2 is treated as machine mode. Virtualization
// is ignored in machine mode and when HAS_H is 0.
module cyc_mode_gate
    import cyc_filt_pkg::*;
#(
    parameter bit HAS_H = 1'b1
) (
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic               tick_i,
    input  logic [NUM_INH-1:0] inh_q,
    output logic               is_mach,
    output logic               inc
);

    logic               virt_eff;
    logic [NUM_INH-1:0] mode_oh;

    assign virt_eff = HAS_H & virt_i;

    // One-hot current mode in inhibit-vector order.
    always_comb begin
        mode_oh = '0;
        unique case (priv_i)
            PRIV_U:  mode_oh[virt_eff ? IDX_VU : IDX_U] = 1'b1;
            PRIV_S:  mode_oh[virt_eff ? IDX_VS : IDX_S] = 1'b1;
            default: mode_oh[IDX_M] = 1'b1;
        endcase
    end

    assign is_mach = (priv_i == PRIV_M);
    assign inc     = tick_i & ~(|(mode_oh & inh_q));

endmodule

// File: rtl/cyc_counter.sv
// 64-bit cycle counter with two half-word write ports. A write beats the
// increment in the same cycle. Assumes CNT_W is even.
module cyc_counter #(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0]   count
);

    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Count, with a software write taking priority over the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) count[HALF-1:0]     <= wdata;
            if (wr_hi) count[CNT_W-1:HALF] <= wdata;
        end else if (inc) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/cyc_csr_port.sv
// CSR decode. It matches the four block addresses, flags any access made
// from below machine mode, produces the qualified write strobes and muxes
// the read data. Assumes XLEN is 32.
module cyc_csr_port
    import cyc_filt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                csr_valid,
    input  logic                csr_we,
    input  logic [11:0]         csr_addr,
    input  logic                is_mach,
    input  logic [NUM_INH-1:0]  inh_q,
    input  logic [2*XLEN-1:0]   count,
    output logic [XLEN-1:0]     csr_rdata,
    output logic                csr_illegal,
    output logic                cfg_we,
    output logic                cnt_wr_lo,
    output logic                cnt_wr_hi
);

    logic hit_cfg_lo, hit_cfg_hi, hit_cnt_lo, hit_cnt_hi, hit_any, ok, wr_ok;
    logic [XLEN-1:0] cfg_hi_view;

    assign hit_cfg_lo = (csr_addr == ADDR_CFG_LO);
    assign hit_cfg_hi = (csr_addr == ADDR_CFG_HI);
    assign hit_cnt_lo = (csr_addr == ADDR_CNT_LO);
    assign hit_cnt_hi = (csr_addr == ADDR_CNT_HI);
    assign hit_any    = hit_cfg_lo | hit_cfg_hi | hit_cnt_lo | hit_cnt_hi;

    assign csr_illegal = csr_valid & hit_any & ~is_mach;
    assign ok          = csr_valid & is_mach;
    assign wr_ok       = ok & csr_we;

    assign cfg_we    = wr_ok & hit_cfg_hi;
    assign cnt_wr_lo = wr_ok & hit_cnt_lo;
    assign cnt_wr_hi = wr_ok & hit_cnt_hi;

    // Upper configuration view: top bit and reserved field read zero.
    always_comb begin
        cfg_hi_view = '0;
        cfg_hi_view[INH_LSB +: NUM_INH] = inh_q;
    end

    // Read mux; an illegal or unmapped access returns zero.
    always_comb begin
        csr_rdata = '0;
        if (ok) begin
            if (hit_cfg_hi) csr_rdata = cfg_hi_view;
            if (hit_cnt_lo) csr_rdata = count[XLEN-1:0];
            if (hit_cnt_hi) csr_rdata = count[2*XLEN-1:XLEN];
        end
    end

endmodule

// File: rtl/cyc_cnt_filter.sv
// Top level. A machine cycle counter that skips ticks while the hart runs in
// a mode whose inhibit bit is set. HAS_S and HAS_H choose which modes exist.
// The lower configuration half is all reserved, so it has no storage.
module cyc_cnt_filter
    import cyc_filt_pkg::*;
#(
    parameter bit HAS_S = 1'b1,
    parameter bit HAS_H = 1'b1,
    parameter int XLEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_valid,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              tick_i,
    output logic [2*XLEN-1:0] count_o
);

    localparam int CNT_W = 2 * XLEN;

    logic [NUM_INH-1:0] inh_q;
    logic is_mach, inc, cfg_we, cnt_wr_lo, cnt_wr_hi;

    cyc_cfg_reg #(.HAS_S(HAS_S), .HAS_H(HAS_H && HAS_S)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (csr_wdata[INH_LSB +: NUM_INH]),
        .inh_q (inh_q)
    );

    cyc_mode_gate #(.HAS_H(HAS_H && HAS_S)) u_gate (
        .priv_i  (priv_i),
        .virt_i  (virt_i),
        .tick_i  (tick_i),
        .inh_q   (inh_q),
        .is_mach (is_mach),
        .inc     (inc)
    );

    cyc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .wr_lo (cnt_wr_lo),
        .wr_hi (cnt_wr_hi),
        .wdata (csr_wdata),
        .count (count_o)
    );

    cyc_csr_port #(.XLEN(XLEN)) u_csr (
        .csr_valid   (csr_valid),
        .csr_we      (csr_we),
        .csr_addr    (csr_addr),
        .is_mach     (is_mach),
        .inh_q       (inh_q),
        .count       (count_o),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal),
        .cfg_we      (cfg_we),
        .cnt_wr_lo   (cnt_wr_lo),
        .cnt_wr_hi   (cnt_wr_hi)
    );

endmodule

// File: rtl/cyc_cnt_filter_chk.sv
// Checker for cyc_cnt_filter, attached with bind. It watches the ports and
// the stored inhibit vector.
module cyc_cnt_filter_chk
    import cyc_filt_pkg::*;
#(
    parameter bit HAS_S = 1'b1,
    parameter bit HAS_H = 1'b1,
    parameter int XLEN  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_valid,
    input logic              csr_we,
    input logic [11:0]       csr_addr,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [XLEN-1:0]   csr_rdata,
    input logic              csr_illegal,
    input logic [1:0]        priv_i,
    input logic              tick_i,
    input logic [2*XLEN-1:0] count_o,
    input logic [NUM_INH-1:0] inh_q
);

    localparam logic [NUM_INH-1:0] IMPL = impl_mask(HAS_S, HAS_H);
    localparam logic [XLEN-1:0] LIVE = {{(XLEN-INH_LSB-NUM_INH){1'b0}}, IMPL, {INH_LSB{1'b0}}};

    logic any_wr;
    assign any_wr = csr_valid & csr_we;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !any_wr) |=> $stable(count_o));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && priv_i == PRIV_M && !inh_q[IDX_M] && !any_wr)
        |=> count_o == $past(count_o) + 1);

    // R7
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0);

    // R7
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_illegal && csr_we) |=> $stable(inh_q));

    // R2
    cfg_hi_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && !csr_we && priv_i == PRIV_M && csr_addr == ADDR_CFG_HI)
        |-> (csr_rdata & ~LIVE) == '0);

    // R9
    cnt_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && priv_i == PRIV_M && csr_addr == ADDR_CNT_LO)
        |=> count_o[XLEN-1:0] == $past(csr_wdata));

endmodule

bind cyc_cnt_filter cyc_cnt_filter_chk #(.HAS_S(HAS_S), .HAS_H(HAS_H && HAS_S), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .priv_i      (priv_i),
    .tick_i      (tick_i),
    .count_o     (count_o),
    .inh_q       (inh_q)
);

// File: tb/cyc_cnt_filter_test.sv
`timescale 1ns/1ps
module cyc_cnt_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  priv_i = 2'b11;
    logic        virt_i = 1'b0, tick_i = 1'b0;
    logic [31:0] rdata, rdata_min;
    logic        ill, ill_min;
    logic [63:0] cnt, cnt_min;

    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    cyc_cnt_filter uut (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(rdata),
        .csr_illegal(ill), .priv_i(priv_i), .virt_i(virt_i), .tick_i(tick_i),
        .count_o(cnt));

    cyc_cnt_filter #(.HAS_S(1'b0), .HAS_H(1'b0)) uut_min (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(rdata_min),
        .csr_illegal(ill_min), .priv_i(priv_i), .virt_i(virt_i), .tick_i(tick_i),
        .count_o(cnt_min));

    // Vector: {inhibit[4:0] (M,S,U,VS,VU), priv[1:0], virt, expected delta over 4 ticks}
    localparam logic [10:0] VEC [10] = '{
        {5'b00000, 2'd0, 1'b0, 3'd4},
        {5'b10000, 2'd3, 1'b0, 3'd0},
        {5'b10000, 2'd0, 1'b0, 3'd4},
        {5'b01000, 2'd1, 1'b0, 3'd0},
        {5'b00100, 2'd0, 1'b0, 3'd0},
        {5'b00100, 2'd0, 1'b1, 3'd4},
        {5'b00010, 2'd1, 1'b1, 3'd0},
        {5'b00001, 2'd0, 1'b1, 3'd0},
        {5'b11110, 2'd0, 1'b1, 3'd4},
        {5'b01111, 2'd1, 1'b0, 3'd0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b0; csr_addr = a;
        #1;
        csr_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] base, base_min;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 count", cnt, 64'd0);
        rd(12'h721); check("R1 cfg", {32'd0, rdata}, 64'd0);

        // R2/R5/R6: readback masking on full and reduced instances
        wr(12'h721, 32'hFFFF_FFFF);
        rd(12'h721);
        check("R2 full cfg hi", {32'd0, rdata}, 64'h7C00_0000);
        check("R5 min cfg hi", {32'd0, rdata_min}, 64'h5000_0000);
        wr(12'h721, 32'h03FF_FFFF);
        rd(12'h721); check("R6 reserved hi", {32'd0, rdata}, 64'd0);
        wr(12'h321, 32'hFFFF_FFFF);
        rd(12'h321); check("R6 cfg lo", {32'd0, rdata}, 64'd0);

        // R3/R4: vector table
        for (int i = 0; i < 10; i++) begin
            wr(12'h721, {1'b0, VEC[i][10:6], 26'd0});
            rd(12'hB00); base = rdata;
            priv_i = VEC[i][5:4]; virt_i = VEC[i][3];
            ticks(4);
            priv_i = 2'b11; virt_i = 1'b0;
            rd(12'hB00);
            check($sformatf("R3 R4 vec%0d", i), {32'd0, rdata - base}, {61'd0, VEC[i][2:0]});
        end

        // R5: VS/VU inhibits only; reduced instance ignores virt and keeps counting
        wr(12'h721, 32'h0C00_0000);
        rd(12'hB00); base = rdata; base_min = rdata_min;
        priv_i = 2'b00; virt_i = 1'b1;
        ticks(4);
        priv_i = 2'b11; virt_i = 1'b0;
        rd(12'hB00);
        check("R5 full VU held", {32'd0, rdata - base}, 64'd0);
        check("R5 min counts", {32'd0, rdata_min - base_min}, 64'd4);

        // R7: user-mode write is flagged and dropped
        wr(12'h721, 32'd0);
        priv_i = 2'b00;
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = 12'h721; csr_wdata = 32'h4000_0000;
        #1 check("R7 illegal", {63'd0, ill}, 64'd1);
        check("R7 rdata zero", {32'd0, rdata}, 64'd0);
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
        priv_i = 2'b11;
        rd(12'h721); check("R7 no write", {32'd0, rdata}, 64'd0);
        check("R7 legal flag", {63'd0, ill}, 64'd0);
        priv_i = 2'b01; virt_i = 1'b1;
        rd(12'hB00); check("R7 vs illegal", {63'd0, ill}, 64'd1);
        priv_i = 2'b11; virt_i = 1'b0;

        // R8: half writes and carry
        wr(12'hB80, 32'h1234_5678);
        wr(12'hB00, 32'hFFFF_FFFF);
        ticks(1);
        rd(12'hB80); check("R8 carry hi", {32'd0, rdata}, 64'h1234_5679);
        rd(12'hB00); check("R8 carry lo", {32'd0, rdata}, 64'd0);

        // R9: write beats tick
        @(negedge clk);
        tick_i = 1'b1;
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = 12'hB00; csr_wdata = 32'h100;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0; tick_i = 1'b0;
        rd(12'hB00); check("R9 write prio", {32'd0, rdata}, 64'h100);
        ticks(1);
        rd(12'hB00); check("R9 resume", {32'd0, rdata}, 64'h101);

        // R10: inhibit written with a tick applies from the next cycle
        wr(12'hB00, 32'd0);
        @(negedge clk);
        tick_i = 1'b1;
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = 12'h721; csr_wdata = 32'h4000_0000;
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
        repeat (3) @(negedge clk);
        tick_i = 1'b0;
        rd(12'hB00); check("R10 one tick", {32'd0, rdata}, 64'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule